// File: doc/BRIEF.md
# Zero Run-Length Codec with Length Rewrite

This block is one byte-serial stage of a lossless storage compression path. In encode mode it replaces every run of zero bytes with a zero byte followed by a byte that holds the number of extra zeros in the run. In decode mode it reverses this, expanding each zero and count pair back into a run of zeros. A transaction arrives on a valid/ready bus as one header beat that carries the mode and the input byte count, followed by that many data beats with one byte each.

The coded length is only known once the last input byte has been handled. The stage therefore consumes the whole transaction first and holds the result internally. It then sends a new header with the rewritten byte count, followed by the coded data. Encode stores its coded output, which can grow to twice the input when zeros are isolated. Decode stores the raw coded input and expands it while sending, so a short input can turn into a long run of zeros without a large buffer.

The stage accepts nothing new until the previous result has drained. A decode stream whose final byte is a zero with no count after it is still decoded, and the transaction is flagged.

Top module: `zrl_codec`

## Requirements
- R1: Encode turns a run of zeros into the byte 0 followed by a count of the extra zeros, and passes nonzero bytes through unchanged: 30,0,0,0,0,0,25,26 becomes 30,0,4,25,26.
- R2: Encode turns an isolated zero into 0,0. A run still open at the end of the input is closed with its count byte before the length is fixed. The output may therefore be longer than the input: 4,0,0,0,0,3,0,2,0,7,1,0 becomes the 13 bytes 4,0,3,3,0,0,2,0,0,7,1,0,0. A 512-byte input alternating zero and nonzero gives 768 bytes.
- R3: One pair covers at most 256 zeros, and a longer run starts a new pair: 256 zeros give 0,255; 257 zeros give 0,255,0,0; 512 zeros give 0,255,0,255.
- R4: Decode passes nonzero bytes through unchanged, and turns a zero followed by a count byte c into 1+c zeros: 0,255,7 becomes 256 zeros and then 7.
- R5: In decode, a zero in the last input position with no count byte after it produces a single zero, and out_err is 1 for the whole output of that transaction. out_err returns to 0 when the next header is accepted.
- R6: An input header has in_hdr=1, the mode in bit 23 (0 encode, 1 decode) and the data beat count 0..512 in bits [9:0]. Each data beat carries its byte in bits [7:0]. An output header has out_hdr=1, the mode copied into bit 23 and the coded byte count in bits [16:0]. It is followed by exactly that many data beats with out_hdr=0 and the byte in bits [7:0].
- R7: The output header appears only after every input data beat has been consumed. in_ready stays 0 from the last input beat until the last output beat has been accepted, so a waiting header is not taken early.
- R8: During the data phase in_ready stays high, so N data beats presented back to back are taken in N consecutive cycles.
- R9: While the stage is idle, a beat with in_hdr=0 is accepted and discarded. It produces no output and does not change the next transaction.
- R10: A header with a count of 0 produces an output header with length 0 and no data beats.
- R11: While out_valid is 1 and out_ready is 0, out_word, out_hdr and out_err hold their values.
- R12: After reset, out_valid=0, in_ready=1 and out_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can take an input beat |
| in_hdr | input | 1 | Input beat is a header |
| in_word | input | 24 | Header: mode bit 23 and count [9:0]; data: byte [7:0] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_hdr | output | 1 | Output beat is a header |
| out_word | output | 24 | Header: mode bit 23 and length [16:0]; data: byte [7:0] |
| out_err | output | 1 | Decode input ended on a zero with no count byte |

## Verification
The hardest conditions to reach from the ports are the 256-zero pair boundary and a zero run that is still open when the input ends. Both depend on the exact length of a run relative to the end of the transaction. Directed transactions of exactly 256, 257 and 512 zeros, and inputs that end on an isolated zero, put the encoder into those states. Decode expansion is tested with slow and irregular out_ready, so that zero runs are emitted across stalled cycles, and with a coded stream cut off after a trailing zero. A held header during drain probes whether a new transaction is blocked.

// File: rtl/zrl_pkg.sv
package zrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE,
        ST_SEAL,
        ST_HEAD,
        ST_EMIT
    } phase_e;

    typedef enum logic {
        MODE_PACK   = 1'b0,
        MODE_UNPACK = 1'b1
    } mode_e;

    // up to two buffer writes per cycle, at consecutive addresses
    typedef struct packed {
        logic       en0;
        logic       en1;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [1:0] adv;
    } wr_pair_t;

    function automatic logic is_zero(input logic [7:0] b);
        return b == 8'd0;
    endfunction

endpackage

// File: rtl/zrl_store.sv
module zrl_store #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we0,
    input  logic              we1,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wd0,
    input  logic [7:0]        wd1,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rd0,
    output logic [7:0]        rd1
);
    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] waddr1;
    logic [ADDR_W-1:0] raddr1;

    assign waddr1 = waddr + 1'b1;
    assign raddr1 = raddr + 1'b1;

    always_ff @(posedge clk) begin
        if (we0) mem[waddr]  <= wd0;
        if (we1) mem[waddr1] <= wd1;
    end

    assign rd0 = mem[raddr];
    assign rd1 = mem[raddr1];
endmodule

// File: rtl/zrl_pack_step.sv
module zrl_pack_step
    import zrl_pkg::*;
#(
    parameter int MAX_RUN = 256
) (
    input  logic [7:0] byte_i,
    input  logic       run_open_i,
    input  logic [7:0] run_cnt_i,
    output wr_pair_t   wr_o,
    output logic       run_open_o,
    output logic [7:0] run_cnt_o
);
    localparam logic [7:0] CNT_LAST = 8'(MAX_RUN - 1);

    always_comb begin
        wr_o       = '0;
        run_open_o = run_open_i;
        run_cnt_o  = run_cnt_i;
        if (is_zero(byte_i)) begin
            if (!run_open_i) begin
                wr_o.en0   = 1'b1;
                wr_o.b0    = 8'd0;
                wr_o.adv   = 2'd1;
                run_open_o = 1'b1;
                run_cnt_o  = 8'd0;
            end else if (run_cnt_i == CNT_LAST) begin
                // close the full pair and open a fresh one
                wr_o.en0  = 1'b1;
                wr_o.b0   = run_cnt_i;
                wr_o.en1  = 1'b1;
                wr_o.b1   = 8'd0;
                wr_o.adv  = 2'd2;
                run_cnt_o = 8'd0;
            end else begin
                run_cnt_o = run_cnt_i + 8'd1;
            end
        end else if (run_open_i) begin
            wr_o.en0   = 1'b1;
            wr_o.b0    = run_cnt_i;
            wr_o.en1   = 1'b1;
            wr_o.b1    = byte_i;
            wr_o.adv   = 2'd2;
            run_open_o = 1'b0;
        end else begin
            wr_o.en0 = 1'b1;
            wr_o.b0  = byte_i;
            wr_o.adv = 2'd1;
        end
    end
endmodule

// File: rtl/zrl_unpack_len.sv
module zrl_unpack_len
    import zrl_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic [7:0]       byte_i,
    input  logic             want_cnt_i,
    input  logic [LEN_W-1:0] acc_i,
    output logic             want_cnt_o,
    output logic [LEN_W-1:0] acc_o
);
    always_comb begin
        if (want_cnt_i) begin
            acc_o      = acc_i + LEN_W'(byte_i);
            want_cnt_o = 1'b0;
        end else begin
            acc_o      = acc_i + LEN_W'(1);
            want_cnt_o = is_zero(byte_i);
        end
    end
endmodule

// File: rtl/zrl_codec.sv
module zrl_codec
    import zrl_pkg::*;
#(
    parameter int MAX_IN  = 512,
    parameter int DEPTH   = 1024,
    parameter int MAX_RUN = 256,
    parameter int WORD_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_hdr,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_hdr,
    output logic [WORD_W-1:0] out_word,
    output logic              out_err
);
    localparam int IN_LEN_W = $clog2(MAX_IN + 1);
    localparam int OUT_MAX  = (MAX_IN / 2) * MAX_RUN;
    localparam int LEN_W    = $clog2(OUT_MAX + 1);
    localparam int ADDR_W   = $clog2(DEPTH);
    localparam int PTR_W    = ADDR_W + 1;
    localparam int MODE_BIT = WORD_W - 1;

    phase_e              phase_q;
    mode_e               mode_q;
    logic [IN_LEN_W-1:0] rem_q;
    logic [PTR_W-1:0]    wptr_q;
    logic [PTR_W-1:0]    rptr_q;
    logic                run_open_q;
    logic [7:0]          run_cnt_q;
    logic                want_cnt_q;
    logic [LEN_W-1:0]    acc_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    sent_q;
    logic [7:0]          zrem_q;
    logic                err_q;

    wr_pair_t            pack_wr;
    logic                pack_open;
    logic [7:0]          pack_cnt;
    logic                ulen_want;
    logic [LEN_W-1:0]    ulen_acc;
    wr_pair_t            wr;
    logic [7:0]          rd_cur;
    logic [7:0]          rd_nxt;
    logic [7:0]          emit_byte;
    logic                nxt_avail;
    logic                out_fire;

    zrl_pack_step #(.MAX_RUN(MAX_RUN)) u_pack (
        .byte_i     (in_word[7:0]),
        .run_open_i (run_open_q),
        .run_cnt_i  (run_cnt_q),
        .wr_o       (pack_wr),
        .run_open_o (pack_open),
        .run_cnt_o  (pack_cnt)
    );

    zrl_unpack_len #(.LEN_W(LEN_W)) u_ulen (
        .byte_i     (in_word[7:0]),
        .want_cnt_i (want_cnt_q),
        .acc_i      (acc_q),
        .want_cnt_o (ulen_want),
        .acc_o      (ulen_acc)
    );

    // buffer write selection: coded bytes for encode, raw bytes for decode
    always_comb begin
        wr = '0;
        if (phase_q == ST_TAKE && in_valid) begin
            if (mode_q == MODE_PACK) begin
                wr = pack_wr;
            end else begin
                wr.en0 = 1'b1;
                wr.b0  = in_word[7:0];
                wr.adv = 2'd1;
            end
        end else if (phase_q == ST_SEAL && mode_q == MODE_PACK && run_open_q) begin
            wr.en0 = 1'b1;
            wr.b0  = run_cnt_q;
            wr.adv = 2'd1;
        end
    end

    zrl_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we0   (wr.en0),
        .we1   (wr.en1),
        .waddr (wptr_q[ADDR_W-1:0]),
        .wd0   (wr.b0),
        .wd1   (wr.b1),
        .raddr (rptr_q[ADDR_W-1:0]),
        .rd0   (rd_cur),
        .rd1   (rd_nxt)
    );

    assign in_ready  = (phase_q == ST_IDLE) || (phase_q == ST_TAKE);
    assign out_valid = (phase_q == ST_HEAD) || (phase_q == ST_EMIT);
    assign out_hdr   = (phase_q == ST_HEAD);
    assign out_err   = err_q;
    assign out_fire  = out_valid && out_ready;
    assign nxt_avail = (rptr_q + PTR_W'(1)) < wptr_q;
    assign emit_byte = (mode_q == MODE_UNPACK && zrem_q != 8'd0) ? 8'd0 : rd_cur;

    always_comb begin
        out_word = '0;
        if (phase_q == ST_HEAD) begin
            out_word[LEN_W-1:0] = len_q;
            out_word[MODE_BIT]  = (mode_q == MODE_UNPACK);
        end else if (phase_q == ST_EMIT) begin
            out_word[7:0] = emit_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= ST_IDLE;
            mode_q     <= MODE_PACK;
            rem_q      <= '0;
            wptr_q     <= '0;
            rptr_q     <= '0;
            run_open_q <= 1'b0;
            run_cnt_q  <= '0;
            want_cnt_q <= 1'b0;
            acc_q      <= '0;
            len_q      <= '0;
            sent_q     <= '0;
            zrem_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            case (phase_q)
                ST_IDLE: begin
                    if (in_valid && in_hdr) begin
                        mode_q     <= in_word[MODE_BIT] ? MODE_UNPACK : MODE_PACK;
                        rem_q      <= in_word[IN_LEN_W-1:0];
                        wptr_q     <= '0;
                        rptr_q     <= '0;
                        run_open_q <= 1'b0;
                        run_cnt_q  <= '0;
                        want_cnt_q <= 1'b0;
                        acc_q      <= '0;
                        sent_q     <= '0;
                        zrem_q     <= '0;
                        err_q      <= 1'b0;
                        phase_q    <= (in_word[IN_LEN_W-1:0] == '0) ? ST_SEAL : ST_TAKE;
                    end
                end
                ST_TAKE: begin
                    if (in_valid) begin
                        wptr_q     <= wptr_q + PTR_W'(wr.adv);
                        run_open_q <= pack_open;
                        run_cnt_q  <= pack_cnt;
                        want_cnt_q <= ulen_want;
                        acc_q      <= ulen_acc;
                        rem_q      <= rem_q - 1'b1;
                        if (rem_q == IN_LEN_W'(1)) phase_q <= ST_SEAL;
                    end
                end
                ST_SEAL: begin
                    wptr_q <= wptr_q + PTR_W'(wr.adv);
                    if (mode_q == MODE_PACK)
                        len_q <= LEN_W'(wptr_q) + LEN_W'(run_open_q);
                    else
                        len_q <= acc_q;
                    err_q      <= (mode_q == MODE_UNPACK) && want_cnt_q;
                    run_open_q <= 1'b0;
                    phase_q    <= ST_HEAD;
                end
                ST_HEAD: begin
                    if (out_fire) phase_q <= (len_q == '0) ? ST_IDLE : ST_EMIT;
                end
                ST_EMIT: begin
                    if (out_fire) begin
                        sent_q <= sent_q + 1'b1;
                        if (sent_q == len_q - 1'b1) phase_q <= ST_IDLE;
                        if (mode_q == MODE_PACK) begin
                            rptr_q <= rptr_q + PTR_W'(1);
                        end else if (zrem_q != 8'd0) begin
                            zrem_q <= zrem_q - 8'd1;
                        end else if (!is_zero(rd_cur)) begin
                            rptr_q <= rptr_q + PTR_W'(1);
                        end else begin
                            zrem_q <= nxt_avail ? rd_nxt : 8'd0;
                            rptr_q <= rptr_q + PTR_W'(2);
                        end
                    end
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zrl_codec_chk.sv
module zrl_codec_chk #(
    parameter int MAX_IN  = 512,
    parameter int MAX_RUN = 256,
    parameter int WORD_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_hdr,
    input logic [WORD_W-1:0] in_word,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_hdr,
    input logic [WORD_W-1:0] out_word,
    input logic              out_err
);
    localparam int IN_LEN_W = $clog2(MAX_IN + 1);
    localparam int OUT_MAX  = (MAX_IN / 2) * MAX_RUN;
    localparam int LEN_W    = $clog2(OUT_MAX + 1);
    localparam int MODE_BIT = WORD_W - 1;

    logic [IN_LEN_W-1:0] in_left;
    logic [LEN_W-1:0]    out_left;
    logic                mode_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_left   <= '0;
            out_left  <= '0;
            mode_seen <= 1'b0;
        end else begin
            if (in_valid && in_ready) begin
                if (in_left == '0 && in_hdr) begin
                    in_left   <= in_word[IN_LEN_W-1:0];
                    mode_seen <= in_word[MODE_BIT];
                end else if (in_left != '0) begin
                    in_left <= in_left - 1'b1;
                end
            end
            if (out_valid && out_ready) begin
                if (out_hdr)
                    out_left <= out_word[LEN_W-1:0];
                else if (out_left != '0)
                    out_left <= out_left - 1'b1;
            end
        end
    end

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R7
    hdr_after_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_left == '0);

    // R8
    take_ready_chk: assert property (@(posedge clk) disable iff (rst)
        in_left != '0 |-> in_ready);

    // R6
    hdr_first_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hdr) |-> out_left == '0);

    // R6
    beat_count_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hdr) |-> out_left != '0);

    // R11
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
                                       $stable(out_hdr) && $stable(out_err)));

    // R5
    err_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> mode_seen);
endmodule

bind zrl_codec zrl_codec_chk #(
    .MAX_IN  (MAX_IN),
    .MAX_RUN (MAX_RUN),
    .WORD_W  (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_hdr    (in_hdr),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hdr   (out_hdr),
    .out_word  (out_word),
    .out_err   (out_err)
);

// File: tb/zrl_codec_tb.sv
module zrl_codec_tb;
    typedef logic [7:0] q8_t [$];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_hdr = 1'b0;
    logic [23:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_hdr;
    logic [23:0] out_word;
    logic        out_err;

    int checks = 0;
    int fails  = 0;
    int stall_kind = 0;
    int tick = 0;
    bit probe_on = 1'b0;
    bit prev_stall = 1'b0;
    logic [23:0] prev_w = '0;

    always #5 clk = ~clk;

    zrl_codec u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_hdr    (in_hdr),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_hdr   (out_hdr),
        .out_word  (out_word),
        .out_err   (out_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic q8_t ref_pack(q8_t d);
        q8_t r;
        int i = 0;
        while (i < d.size()) begin
            if (d[i] != 8'd0) begin
                r.push_back(d[i]);
                i++;
            end else begin
                int n = 0;
                while (i < d.size() && d[i] == 8'd0 && n < 256) begin
                    n++;
                    i++;
                end
                r.push_back(8'd0);
                r.push_back(8'(n - 1));
            end
        end
        return r;
    endfunction

    function automatic q8_t ref_unpack(q8_t d, output bit err);
        q8_t r;
        int i = 0;
        err = 1'b0;
        while (i < d.size()) begin
            if (d[i] != 8'd0) begin
                r.push_back(d[i]);
                i++;
            end else begin
                int c = 0;
                if (i + 1 < d.size()) c = int'(d[i+1]);
                else err = 1'b1;
                for (int k = 0; k <= c; k++) r.push_back(8'd0);
                i += 2;
            end
        end
        return r;
    endfunction

    function automatic logic ready_pattern();
        tick++;
        case (stall_kind)
            1: return tick[0];
            2: return (tick % 3) == 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic push_beat(input logic h, input logic [23:0] w, inout int cyc);
        logic acc;
        @(negedge clk);
        in_valid = 1'b1;
        in_hdr   = h;
        in_word  = w;
        forever begin
            acc = in_ready;
            @(posedge clk);
            cyc++;
            if (acc) break;
            @(negedge clk);
        end
    endtask

    task automatic send_txn(input bit md, input q8_t d);
        logic [23:0] hw = '0;
        int cyc = 0;
        hw[23]  = md;
        hw[9:0] = 10'(d.size());
        push_beat(1'b1, hw, cyc);
        cyc = 0;
        foreach (d[i]) push_beat(1'b0, {16'h0, d[i]}, cyc);
        // R8: back-to-back intake, one beat per cycle
        chk(cyc == d.size(), "R8 intake cycles", cyc, d.size());
        @(negedge clk);
        in_valid = 1'b0;
        in_hdr   = 1'b0;
        in_word  = '0;
    endtask

    task automatic pull_beat(output logic h, output logic [23:0] w, output logic e);
        logic v, r;
        forever begin
            @(negedge clk);
            out_ready = ready_pattern();
            if (probe_on) begin
                in_valid = 1'b1;
                in_hdr   = 1'b1;
                in_word  = 24'h000003;
                chk(in_ready == 1'b0, "R7 in_ready during drain", in_ready, 0);
            end
            if (prev_stall)
                chk(out_valid && out_word == prev_w, "R11 hold under stall",
                    int'(out_word), int'(prev_w));
            v = out_valid;
            r = out_ready;
            h = out_hdr;
            w = out_word;
            e = out_err;
            prev_stall = v && !r;
            prev_w     = w;
            @(posedge clk);
            if (v && r) break;
        end
    endtask

    task automatic pull_txn(input bit md, input q8_t exp, input bit exp_err, input string tag);
        logic h, e;
        logic [23:0] w;
        pull_beat(h, w, e);
        chk(h == 1'b1, {tag, " R6 header flag"}, h, 1);
        chk(w[23] == md, {tag, " R6 header mode"}, w[23], md);
        chk(int'(w[16:0]) == exp.size(), {tag, " R6 header length"}, int'(w[16:0]), exp.size());
        chk(e == exp_err, {tag, " R5 error flag"}, e, exp_err);
        foreach (exp[i]) begin
            pull_beat(h, w, e);
            chk(h == 1'b0 && w[7:0] == exp[i], {tag, " data byte"}, int'(w[7:0]), int'(exp[i]));
        end
        @(negedge clk);
        out_ready = 1'b0;
        if (probe_on) begin
            in_valid = 1'b0;
            in_hdr   = 1'b0;
            in_word  = '0;
        end
        prev_stall = 1'b0;
    endtask

    task automatic run_txn(input bit md, input q8_t d, input q8_t exp, input bit exp_err, input string tag);
        send_txn(md, d);
        pull_txn(md, exp, exp_err, tag);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R12 in_ready after reset", in_ready, 1);
        chk(out_err == 1'b0, "R12 out_err after reset", out_err, 0);
    endtask

    task automatic t_example();
        q8_t d = '{30, 0, 0, 0, 0, 0, 25, 26};
        q8_t x = '{30, 0, 4, 25, 26};
        run_txn(1'b0, d, x, 1'b0, "R1 run example");
    endtask

    task automatic t_expand();
        q8_t d = '{4, 0, 0, 0, 0, 3, 0, 2, 0, 7, 1, 0};
        q8_t x = '{4, 0, 3, 3, 0, 0, 2, 0, 0, 7, 1, 0, 0};
        q8_t a;
        q8_t xa;
        run_txn(1'b0, d, x, 1'b0, "R2 isolated zeros");
        for (int i = 0; i < 512; i++) a.push_back((i % 2 == 0) ? 8'd0 : 8'((i % 200) + 1));
        xa = ref_pack(a);
        chk(xa.size() == 768, "R2 worst-case model length", xa.size(), 768);
        stall_kind = 1;
        run_txn(1'b0, a, xa, 1'b0, "R2 alternating 512");
        stall_kind = 0;
    endtask

    task automatic t_long_runs();
        q8_t z256, z257, z512;
        q8_t x256 = '{0, 255};
        q8_t x257 = '{0, 255, 0, 0};
        q8_t x512 = '{0, 255, 0, 255};
        for (int i = 0; i < 256; i++) z256.push_back(8'd0);
        for (int i = 0; i < 257; i++) z257.push_back(8'd0);
        for (int i = 0; i < 512; i++) z512.push_back(8'd0);
        run_txn(1'b0, z256, x256, 1'b0, "R3 256 zeros");
        stall_kind = 2;
        run_txn(1'b0, z257, x257, 1'b0, "R3 257 zeros");
        stall_kind = 0;
        run_txn(1'b0, z512, x512, 1'b0, "R3 512 zeros");
    endtask

    task automatic t_unpack();
        q8_t d1 = '{30, 0, 4, 25, 26};
        q8_t x1 = '{30, 0, 0, 0, 0, 0, 25, 26};
        q8_t d2 = '{0, 255, 7};
        q8_t x2;
        for (int i = 0; i < 256; i++) x2.push_back(8'd0);
        x2.push_back(8'd7);
        run_txn(1'b1, d1, x1, 1'b0, "R4 decode example");
        stall_kind = 2;
        run_txn(1'b1, d2, x2, 1'b0, "R4 decode long run");
        stall_kind = 0;
    endtask

    task automatic t_trunc();
        q8_t d1 = '{5, 0};
        q8_t x1 = '{5, 0};
        q8_t d2 = '{1, 2};
        q8_t x2 = '{1, 2};
        bit e;
        q8_t m = ref_unpack(d1, e);
        chk(e == 1'b1 && m.size() == 2, "R5 model truncation", m.size(), 2);
        stall_kind = 1;
        run_txn(1'b1, d1, x1, 1'b1, "R5 trailing zero");
        stall_kind = 0;
        run_txn(1'b1, d2, x2, 1'b0, "R5 flag cleared");
    endtask

    task automatic t_roundtrip();
        q8_t d, c, back;
        bit e;
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d.push_back((lfsr[2:0] < 3'd5) ? 8'd0 : lfsr[15:8]);
        end
        c = ref_pack(d);
        stall_kind = 1;
        run_txn(1'b0, d, c, 1'b0, "R1 mixed encode");
        back = ref_unpack(c, e);
        chk(back == d, "R4 model roundtrip", back.size(), d.size());
        run_txn(1'b1, c, d, 1'b0, "R4 mixed decode");
        stall_kind = 0;
    endtask

    task automatic t_stray();
        int cyc = 0;
        q8_t d = '{1, 0, 2};
        q8_t x = '{1, 0, 0, 2};
        push_beat(1'b0, 24'h00005A, cyc);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R9 stray beat gives no output", out_valid, 0);
        chk(in_ready == 1'b1, "R9 still idle after stray beat", in_ready, 1);
        run_txn(1'b0, d, x, 1'b0, "R9 after stray beat");
    endtask

    task automatic t_zero_len();
        q8_t d;
        q8_t x;
        run_txn(1'b0, d, x, 1'b0, "R10 empty");
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 no data after empty header", out_valid, 0);
    endtask

    task automatic t_block();
        q8_t d = '{9, 0, 0, 8};
        q8_t x = '{9, 0, 1, 8};
        send_txn(1'b0, d);
        @(negedge clk);
        chk(in_ready == 1'b0, "R7 input closed before header", in_ready, 0);
        probe_on = 1'b1;
        stall_kind = 2;
        pull_txn(1'b0, x, 1'b0, "R7 held header");
        probe_on = 1'b0;
        stall_kind = 0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R7 held header not taken", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_example();
        t_expand();
        t_long_runs();
        t_unpack();
        t_trunc();
        t_roundtrip();
        t_stray();
        t_zero_len();
        t_block();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule